// File: doc/BRIEF.md
# Serial Sampling ADC Readout Controller

This block is the host side of a three-wire link to a serial sampling converter. It drives the convert strobe and the shift clock and reads the serial data line. Every conversion it runs follows the same pattern. The convert strobe is raised and held for the conversion time with the shift clock parked low. The strobe is then dropped, which makes the converter present its most significant bit. The controller samples that bit before it issues any clock pulse. It then produces one fewer clock pulse than there are data bits, collecting one bit per pulse. The finished word is handed over on a valid/ready pair. If the previous word has not yet been taken, the new word waits inside the block rather than overwriting it.

Conversions start either from a command or from a programmable period counter. The same command input can also emit the power sequences the converter understands:
- two short strobe pulses with the clock idle put it into a light power-down;
- four such pulses put it into deep power-down;
- a single clock pulse wakes it.

After a wake from deep power-down the block stays busy for a parameterised recovery time before it accepts the next command. Every timing constant is counted in system clock cycles. An elaboration-time check compares each constant with the converter's minimum times.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and after reset, `adc_conv`, `adc_sck`, `busy` and `data_valid` are low.
- R2: A convert command (`cmd_op` = 0) holds `adc_conv` high for exactly CONV_CYC cycles, and `adc_sck` is never high while `adc_conv` is high.
- R3: After `adc_conv` falls, exactly DATA_W-1 clock pulses follow. Each high phase lasts SCK_HI_CYC cycles and each low phase lasts SCK_LO_CYC cycles, counting the phase between the strobe fall and the first rising edge.
- R4: The word is assembled MSB first, with bit DATA_W-1 taken from `adc_sdo` in the last cycle before the first clock rise. Each later bit is taken in the last cycle of the following low phase, so the delivered word equals the value the converter shifted out.
- R5: While `data_valid` is high and `data_ready` is low, `data_valid` stays high and `data_word` does not change. `data_valid` drops in the cycle after a cycle with both high.
- R6: Two conversion strobe rises are at least THRU_CYC cycles apart. The strobe never rises within QUIET_CYC cycles of a clock fall.
- R7: A light power-down command (`cmd_op` = 1) produces two strobe pulses, each PULSE_CYC cycles high. It produces no clock pulse and no data word.
- R8: A deep power-down command (`cmd_op` = 2) produces four strobe pulses. Until the next wake, period ticks start no conversion.
- R9: A wake command (`cmd_op` = 3) produces one clock pulse with the strobe low. After a deep power-down, `busy` stays high for at least the recovery time (SLEEP_RECOVER_PS rounded up to cycles). After a light power-down it does not.
- R10: `busy` is high from the cycle after a command is accepted until its sequence ends. A `cmd_valid` seen while `busy` is high starts nothing.
- R11: With a nonzero `period`, an idle controller starts a conversion every `period` cycles. With `period` at zero, no conversion starts without a command.
- R12: A finished word that meets an occupied output keeps `busy` high and waits. It is delivered, unchanged, after the earlier word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken only while not busy |
| cmd_op | input | 2 | 0 convert, 1 light power-down, 2 deep power-down, 3 wake |
| period | input | PER_W | Automatic conversion period in cycles, 0 disables |
| busy | output | 1 | A sequence is in progress |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Shift clock to the converter |
| adc_sdo | input | 1 | Serial data from the converter |
| data_valid | output | 1 | Output word is valid |
| data_ready | input | 1 | Consumer takes the word |
| data_word | output | DATA_W | Assembled conversion result |

## Verification
The assertions assume a few things about the inputs:
- `adc_sdo` is settled by the end of each low phase, since the converter moves it only on clock falls.
- `data_ready` is an ordinary synchronous input.
- Commands are judged only at clock edges.

The bench's converter model updates its data line on the strobe fall and on each clock fall. That keeps every change at least a full low phase away from the sampling edge. The bench drives commands, `period` and `data_ready` at falling clock edges, and issues commands only after it has seen `busy` low, except in the test that deliberately offers commands while busy. The recovery time is shortened through its parameter so that the wake sequence fits in a short run.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the ADC readout controller.
// Assumes: command codes are fixed by the external command bus.
package adc_rd_pkg;

    typedef enum logic [1:0] {
        OP_CONVERT = 2'd0,
        OP_NAP     = 2'd1,
        OP_SLEEP   = 2'd2,
        OP_WAKE    = 2'd3
    } adc_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CONV,
        S_RLO,
        S_RHI,
        S_DONE,
        S_QUIET,
        S_GAP,
        S_PHI,
        S_PLO,
        S_WHI,
        S_WLO,
        S_WAIT
    } rd_state_e;

endpackage

// File: rtl/adc_rd_tick.sv
`timescale 1ns/1ps
// Period timer: pulses tick once every `period` cycles; period 0 stops it.
// Assumes: a change of period takes effect from the running count.
module adc_rd_tick #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    logic [PER_W-1:0] cnt;

    assign tick = (period != '0) && (cnt >= period - 1'b1);

    // Free-running count that wraps at the programmed period.
    always_ff @(posedge clk) begin
        if (!rst_n || period == '0 || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_rd_shift.sv
`timescale 1ns/1ps
// Input shifter: collects serial bits MSB first on each capture strobe.
// Assumes: the data line is stable in the cycle where cap is high.
module adc_rd_shift #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic              sdo,
    output logic [DATA_W-1:0] word
);

    // Clear at conversion start, shift one bit in per capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (cap) begin
            word <= {word[DATA_W-2:0], sdo};
        end
    end

endmodule

// File: rtl/adc_rd_hold.sv
`timescale 1ns/1ps
// Output register with valid/ready handshake.
// Assumes: the producer loads only while valid is low.
module adc_rd_hold #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);

    // Set valid on load, clear it when the consumer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(dout)));

    p_take_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !load) |=> !valid);

endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
// Host-side readout controller for a three-wire serial sampling ADC.
// Runs convert/readout, the pulse-count power commands and the wake
// sequence, and counts every timing gap in system clock cycles.
// Assumes: adc_sdo changes only on shift clock falls and strobe falls.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_PS           = 5000,
    parameter int DATA_W           = 14,
    parameter int CONV_CYC         = 260,
    parameter int SCK_HI_CYC       = 5,
    parameter int SCK_LO_CYC       = 5,
    parameter int QUIET_CYC        = 3,
    parameter int THRU_CYC         = 400,
    parameter int PULSE_CYC        = 2,
    parameter int NAP_PULSES       = 2,
    parameter int SLEEP_PULSES     = 4,
    parameter int SLEEP_RECOVER_PS = 1_100_000_000,
    parameter int PER_W            = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PER_W-1:0]  period,
    output logic              busy,
    output logic              adc_conv,
    output logic              adc_sck,
    input  logic              adc_sdo,
    output logic              data_valid,
    input  logic              data_ready,
    output logic [DATA_W-1:0] data_word
);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WAKE_CYC = (SLEEP_RECOVER_PS + CLK_PS - 1) / CLK_PS;
    localparam int TMR_MAX  = max2(max2(max2(CONV_CYC, WAKE_CYC), max2(SCK_HI_CYC, SCK_LO_CYC)),
                                   max2(QUIET_CYC, PULSE_CYC));
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int THR_W    = $clog2(THRU_CYC + 1);
    localparam int PC_W     = $clog2(max2(NAP_PULSES, SLEEP_PULSES) + 1);
    localparam int QA_W     = $clog2(QUIET_CYC + 1);

    // Elaboration-time timing checks against the converter minimums.
    if (CONV_CYC * CLK_PS < 1_300_000) begin : g_bad_conv
        $error("conversion hold shorter than 1300 ns");
    end
    if ((SCK_HI_CYC + SCK_LO_CYC) * CLK_PS < 50_000) begin : g_bad_sck_period
        $error("shift clock period shorter than 50 ns");
    end
    if (SCK_HI_CYC * CLK_PS < 10_000) begin : g_bad_sck_hi
        $error("shift clock high phase shorter than 10 ns");
    end
    if (SCK_LO_CYC * CLK_PS < 15_000) begin : g_bad_sck_lo
        $error("low phase too short for setup and data access");
    end
    if (QUIET_CYC * CLK_PS < 15_000) begin : g_bad_quiet
        $error("quiet gap shorter than 15 ns");
    end
    if (THRU_CYC * CLK_PS < 2_000_000) begin : g_bad_thru
        $error("throughput interval shorter than 2000 ns");
    end
    if (PULSE_CYC * CLK_PS < 10_000) begin : g_bad_pulse
        $error("command pulse shorter than 10 ns");
    end
    if (DATA_W < 2) begin : g_bad_width
        $error("word width must be at least 2");
    end

    rd_state_e         state, state_nx;
    logic [TMR_W-1:0]  tmr, tmr_nx;
    logic [BIT_W-1:0]  bit_idx, bit_nx;
    logic [PC_W-1:0]   pulses_left, pl_nx;
    logic [THR_W-1:0]  thr_cnt;
    logic              sleep_seq, sleep_seq_nx;
    logic              asleep, asleep_nx;
    logic              pending;
    logic              tick, cap, clr, load, start_conv;
    logic              conv_q, sck_q;
    logic [DATA_W-1:0] shift_word;

    assign busy     = (state != S_IDLE);
    assign adc_conv = conv_q;
    assign adc_sck  = sck_q;

    adc_rd_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .period(period), .tick(tick)
    );

    adc_rd_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cap(cap), .sdo(adc_sdo), .word(shift_word)
    );

    adc_rd_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .din(shift_word), .ready(data_ready),
        .valid(data_valid), .dout(data_word)
    );

    // Sequencer: next state, phase timer and strobes for shifter and holder.
    always_comb begin
        state_nx     = state;
        tmr_nx       = (tmr != '0) ? tmr - 1'b1 : tmr;
        bit_nx       = bit_idx;
        pl_nx        = pulses_left;
        sleep_seq_nx = sleep_seq;
        asleep_nx    = asleep;
        cap          = 1'b0;
        clr          = 1'b0;
        load         = 1'b0;
        start_conv   = 1'b0;
        case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (adc_op_e'(cmd_op))
                        OP_CONVERT: start_conv = 1'b1;
                        OP_NAP: begin
                            state_nx     = S_PHI;
                            tmr_nx       = TMR_W'(PULSE_CYC - 1);
                            pl_nx        = PC_W'(NAP_PULSES);
                            sleep_seq_nx = 1'b0;
                        end
                        OP_SLEEP: begin
                            state_nx     = S_PHI;
                            tmr_nx       = TMR_W'(PULSE_CYC - 1);
                            pl_nx        = PC_W'(SLEEP_PULSES);
                            sleep_seq_nx = 1'b1;
                        end
                        default: begin
                            state_nx = S_WHI;
                            tmr_nx   = TMR_W'(SCK_HI_CYC - 1);
                        end
                    endcase
                end else if (pending && !asleep) begin
                    start_conv = 1'b1;
                end
                if (start_conv) begin
                    state_nx = S_CONV;
                    tmr_nx   = TMR_W'(CONV_CYC - 1);
                    clr      = 1'b1;
                end
            end
            S_CONV: if (tmr == '0) begin
                state_nx = S_RLO;
                tmr_nx   = TMR_W'(SCK_LO_CYC - 1);
                bit_nx   = '0;
            end
            S_RLO: if (tmr == '0) begin
                cap = 1'b1;
                if (bit_idx == BIT_W'(DATA_W - 1)) begin
                    state_nx = S_DONE;
                end else begin
                    state_nx = S_RHI;
                    tmr_nx   = TMR_W'(SCK_HI_CYC - 1);
                end
            end
            S_RHI: if (tmr == '0) begin
                state_nx = S_RLO;
                tmr_nx   = TMR_W'(SCK_LO_CYC - 1);
                bit_nx   = bit_idx + 1'b1;
            end
            S_DONE: if (!data_valid) begin
                load     = 1'b1;
                state_nx = S_QUIET;
                tmr_nx   = TMR_W'(QUIET_CYC - 1);
            end
            S_QUIET: if (tmr == '0) state_nx = S_GAP;
            S_GAP:   if (thr_cnt >= THR_W'(THRU_CYC - 1)) state_nx = S_IDLE;
            S_PHI: if (tmr == '0) begin
                state_nx = S_PLO;
                tmr_nx   = TMR_W'(PULSE_CYC - 1);
            end
            S_PLO: if (tmr == '0) begin
                if (pulses_left == PC_W'(1)) begin
                    state_nx = S_QUIET;
                    tmr_nx   = TMR_W'(QUIET_CYC - 1);
                    if (sleep_seq) asleep_nx = 1'b1;
                end else begin
                    pl_nx    = pulses_left - 1'b1;
                    state_nx = S_PHI;
                    tmr_nx   = TMR_W'(PULSE_CYC - 1);
                end
            end
            S_WHI: if (tmr == '0) begin
                state_nx = S_WLO;
                tmr_nx   = TMR_W'(SCK_LO_CYC - 1);
            end
            S_WLO: if (tmr == '0) begin
                if (asleep) begin
                    state_nx  = S_WAIT;
                    tmr_nx    = TMR_W'(WAKE_CYC - 1);
                    asleep_nx = 1'b0;
                end else begin
                    state_nx = S_QUIET;
                    tmr_nx   = TMR_W'(QUIET_CYC - 1);
                end
            end
            S_WAIT:  if (tmr == '0) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State and sequence registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            tmr         <= '0;
            bit_idx     <= '0;
            pulses_left <= '0;
            sleep_seq   <= 1'b0;
            asleep      <= 1'b0;
        end else begin
            state       <= state_nx;
            tmr         <= tmr_nx;
            bit_idx     <= bit_nx;
            pulses_left <= pl_nx;
            sleep_seq   <= sleep_seq_nx;
            asleep      <= asleep_nx;
        end
    end

    // Glitch-free pin drivers registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            sck_q  <= 1'b0;
        end else begin
            conv_q <= (state_nx == S_CONV) || (state_nx == S_PHI);
            sck_q  <= (state_nx == S_RHI) || (state_nx == S_WHI);
        end
    end

    // Cycles since the last conversion strobe rise, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_cnt <= THR_W'(THRU_CYC);
        end else if (start_conv) begin
            thr_cnt <= '0;
        end else if (thr_cnt < THR_W'(THRU_CYC)) begin
            thr_cnt <= thr_cnt + 1'b1;
        end
    end

    // Period request, held until a conversion starts; dropped while asleep.
    always_ff @(posedge clk) begin
        if (!rst_n || start_conv) begin
            pending <= 1'b0;
        end else if (tick && !asleep) begin
            pending <= 1'b1;
        end
    end

    // Assertion support: low cycles since the last shift clock fall.
    logic [QA_W-1:0] fall_age;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_age <= QA_W'(QUIET_CYC);
        end else if (sck_q) begin
            fall_age <= '0;
        end else if (fall_age < QA_W'(QUIET_CYC)) begin
            fall_age <= fall_age + 1'b1;
        end
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_conv && !adc_sck));

    p_no_sck_in_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv |-> !adc_sck);

    p_quiet_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_conv) |-> (fall_age >= QA_W'(QUIET_CYC)));

    p_sleep_blocks_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && state == S_IDLE && !cmd_valid) |=> (state != S_CONV));

    p_wake_conv_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WHI || state == S_WLO || state == S_WAIT) |-> !adc_conv);

    p_pins_need_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_conv || adc_sck) |-> busy);

    p_done_waits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && data_valid) |=> (state == S_DONE));

endmodule

// File: tb/tb_adc_rd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_rd_ctrl;

    localparam int CONV   = 260;
    localparam int SCK_HI = 5;
    localparam int SCK_LO = 5;
    localparam int QUIET  = 3;
    localparam int THRU   = 400;
    localparam int PULSE  = 2;
    localparam int WAKE   = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] period = '0;
    logic        busy, adc_conv, adc_sck, adc_sdo, data_valid;
    logic        data_ready = 1'b0;
    logic [13:0] data_word;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(.CONV_CYC(CONV), .SCK_HI_CYC(SCK_HI), .SCK_LO_CYC(SCK_LO), .QUIET_CYC(QUIET),
                  .THRU_CYC(THRU), .PULSE_CYC(PULSE), .SLEEP_RECOVER_PS(WAKE * 5000)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .period(period),
        .busy(busy), .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdo(adc_sdo),
        .data_valid(data_valid), .data_ready(data_ready), .data_word(data_word)
    );

    // Converter model: MSB on strobe fall, next bit on each clock fall, then zeros.
    logic [13:0] adc_value = '0;
    logic [13:0] sh = '0;
    always @(negedge adc_conv) sh <= adc_value;
    always @(negedge adc_sck) if (!adc_conv) sh <= {sh[12:0], 1'b0};
    assign adc_sdo = adc_conv ? 1'b0 : sh[13];

    int n_checks = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pin monitor, sampled on falling clock edges.
    int cyc = 0, conv_run = 0, last_conv_hi = 0, conv_rises = 0, sck_rises = 0, sck_in_conv = 0;
    int hi_run = 0, lo_run = 0, hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;
    int last_rise_cyc = -100000, rise_gap = 0, rise_gap_min = 100000, fall_age = 1000, quiet_min = 1000;
    logic conv_p = 1'b0, sck_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (adc_conv) conv_run++;
        if (conv_p && !adc_conv) begin last_conv_hi = conv_run; conv_run = 0; end
        if (adc_conv && !conv_p) begin
            conv_rises++;
            rise_gap = cyc - last_rise_cyc;
            last_rise_cyc = cyc;
            if (rise_gap < rise_gap_min) rise_gap_min = rise_gap;
            if (fall_age < quiet_min) quiet_min = fall_age;
        end
        if (adc_conv && adc_sck) sck_in_conv++;
        if (adc_sck && !sck_p) begin
            sck_rises++;
            if (lo_run < lo_min) lo_min = lo_run;
            if (lo_run > lo_max) lo_max = lo_run;
        end
        if (!adc_sck && sck_p) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (adc_sck) hi_run++;
        if (adc_sck || adc_conv) lo_run = 0; else lo_run++;
        if (adc_sck) fall_age = 0; else fall_age++;
        conv_p = adc_conv;
        sck_p = adc_sck;
    end

    task automatic clear_stats();
        hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
        rise_gap_min = 100000; quiet_min = 1000; sck_in_conv = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op);
        wait_idle();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int i;
        for (i = 0; i < 3000 && !data_valid; i++) @(negedge clk);
        chk(data_valid, req, "word never became valid", 0, 1);
    endtask

    task automatic take_word();
        @(negedge clk);
        data_ready = 1'b1;
        @(negedge clk);
        data_ready = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!adc_conv && !adc_sck, "R1", "pins in reset", {adc_conv, adc_sck}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !data_valid, "R1", "busy/valid after reset", {busy, data_valid}, 0);
        chk(!adc_conv && !adc_sck, "R1", "pins after reset", {adc_conv, adc_sck}, 0);
    endtask

    task automatic t_convert(input logic [13:0] val);
        int s0;
        clear_stats();
        adc_value = val;
        s0 = sck_rises;
        issue(2'd0);
        wait_valid("R4");
        chk(data_word == val, "R4", "word value", data_word, val);
        chk(last_conv_hi == CONV, "R2", "strobe high length", last_conv_hi, CONV);
        chk(sck_in_conv == 0, "R2", "clock high during strobe", sck_in_conv, 0);
        chk(sck_rises - s0 == 13, "R3", "clock pulse count", sck_rises - s0, 13);
        chk(hi_min == SCK_HI && hi_max == SCK_HI, "R3", "high phase", hi_max, SCK_HI);
        chk(lo_min == SCK_LO && lo_max == SCK_LO, "R3", "low phase", lo_min, SCK_LO);
        take_word();
        chk(!data_valid, "R5", "valid after take", data_valid, 0);
        wait_idle();
    endtask

    task automatic t_hold();
        adc_value = 14'h1A2B;
        issue(2'd0);
        wait_valid("R5");
        repeat (60) @(negedge clk);
        chk(data_valid, "R5", "valid held without ready", data_valid, 1);
        chk(data_word == 14'h1A2B, "R5", "word held", data_word, 14'h1A2B);
        take_word();
        chk(!data_valid, "R5", "valid drops after take", data_valid, 0);
        wait_idle();
    endtask

    task automatic t_backlog();
        adc_value = 14'h0F0F;
        issue(2'd0);
        wait_valid("R12");
        adc_value = 14'h3333;
        issue(2'd0);
        repeat (800) @(negedge clk);
        chk(busy, "R12", "busy while word waits", busy, 1);
        chk(data_word == 14'h0F0F, "R12", "first word kept", data_word, 14'h0F0F);
        take_word();
        wait_valid("R12");
        chk(data_word == 14'h3333, "R12", "second word delivered", data_word, 14'h3333);
        take_word();
        wait_idle();
    endtask

    task automatic t_busy_block();
        int c0;
        adc_value = 14'h2468;
        c0 = conv_rises;
        issue(2'd0);
        chk(busy, "R10", "busy after accept", busy, 1);
        cmd_op = 2'd2;
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        wait_valid("R10");
        take_word();
        wait_idle();
        repeat (20) @(negedge clk);
        chk(conv_rises - c0 == 1, "R10", "strobe rises with command offered while busy", conv_rises - c0, 1);
        chk(data_word == 14'h2468, "R10", "word unaffected", data_word, 14'h2468);
    endtask

    task automatic t_throughput();
        clear_stats();
        adc_value = 14'h0001;
        issue(2'd0);
        wait_valid("R6");
        take_word();
        issue(2'd0);
        wait_valid("R6");
        take_word();
        wait_idle();
        chk(rise_gap_min >= THRU, "R6", "strobe rise spacing", rise_gap_min, THRU);
        chk(quiet_min >= QUIET, "R6", "quiet after clock fall", quiet_min, QUIET);
    endtask

    task automatic t_nap();
        int c0, s0;
        c0 = conv_rises; s0 = sck_rises;
        issue(2'd1);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(conv_rises - c0 == 2, "R7", "nap strobe pulses", conv_rises - c0, 2);
        chk(last_conv_hi == PULSE, "R7", "nap pulse width", last_conv_hi, PULSE);
        chk(sck_rises == s0 && !data_valid, "R7", "no clock or word", sck_rises - s0, 0);
    endtask

    task automatic t_sleep();
        int c0;
        c0 = conv_rises;
        issue(2'd2);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(conv_rises - c0 == 4, "R8", "sleep strobe pulses", conv_rises - c0, 4);
        c0 = conv_rises;
        period = 16'd50;
        repeat (600) @(negedge clk);
        chk(conv_rises == c0 && !data_valid, "R8", "period ignored while asleep", conv_rises - c0, 0);
        period = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_wake(input bit from_sleep);
        int c0, s0, blen;
        c0 = conv_rises; s0 = sck_rises;
        issue(2'd3);
        blen = 1;
        for (int i = 0; i < 2000 && busy; i++) begin @(negedge clk); blen++; end
        repeat (3) @(negedge clk);
        chk(sck_rises - s0 == 1, "R9", "wake clock pulses", sck_rises - s0, 1);
        chk(conv_rises == c0, "R9", "strobe during wake", conv_rises - c0, 0);
        if (from_sleep) chk(blen >= WAKE, "R9", "recovery busy length", blen, WAKE);
        else chk(blen < 30, "R9", "wake from nap busy length", blen, 30);
    endtask

    task automatic t_period();
        int c0;
        data_ready = 1'b1;
        period = 16'd600;
        for (int k = 0; k < 4; k++) begin
            @(posedge adc_conv);
            @(negedge clk);
            @(negedge clk);
            if (k > 0) chk(rise_gap == 600, "R11", "periodic spacing", rise_gap, 600);
        end
        period = '0;
        repeat (700) @(negedge clk);
        wait_idle();
        c0 = conv_rises;
        repeat (1500) @(negedge clk);
        chk(conv_rises == c0, "R11", "no start with period zero", conv_rises - c0, 0);
        data_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(14'h2A5C);
        t_convert(14'h3FFF);
        t_convert(14'h0000);
        t_convert(14'h2000);
        t_convert(14'h1555);
        t_hold();
        t_backlog();
        t_busy_block();
        t_throughput();
        t_nap();
        t_wake(1'b0);
        t_sleep();
        t_wake(1'b1);
        t_convert(14'h0ACE);
        t_period();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule